// File: doc/BRIEF.md
# Byte Counter and Command Termination Unit

This block tracks the two 32-bit byte counts that govern a data-processing command and decides the cycle in which the command ends. Accepting a command loads an input-side count and an output-side count from the command's fields. Each consumed input byte decrements the input count. Each produced output byte decrements the output count. Bytes flagged as fill padding are never counted. Alignment bytes and check bytes reach the block as ordinary bytes, so they are counted.

A normal command ends when the input count reaches zero. The output count cannot end it. When the output count is exhausted, further output is suppressed and an overrun flag is raised. Per-command ignore bits turn either counter into a free-running wrap-around counter. A stop request or a data-error report ends the command once the bytes already waiting in the input FIFO have been consumed. A memory-read command ends only when its output count reaches zero. Memory-read and memory-write commands also produce an 11-bit wrapping memory address.

When a command ends, the final counter values and the two flags are captured into a result record and announced with a one-cycle pulse.

Top module: `bcnt_term_unit`

## Requirements
- R1: `cmd_ready` is high exactly when no command is active. A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high, and that command's count fields are loaded into the two counters. `cmd_kind` encodes 0 or 3 as a streaming command, 1 as memory-read and 2 as memory-write.
- R2: On each cycle with `src_valid` and `src_ready` high and `src_pad` low, the input counter decrements by one. A handshaked byte with `src_pad` high leaves the counter unchanged.
- R3: With the ignore-input bit clear, the command terminates on the edge where the input count becomes zero. On the following cycle `res_valid` is high, `res_src_zero` is 1, `res_src_cnt` is 0 and `cmd_ready` is high again.
- R4: With the ignore-input bit set, the input counter wraps from 0 to 0xFFFFFFFF and never terminates the command.
- R5: With the ignore-output bit clear, once the output count is 0 the output counter stays at 0 and `dst_pass` is low. A non-pad output byte in that state sets the overrun flag, which is reported as `res_dst_ovr`. The command keeps running.
- R6: With the ignore-output bit set, on a streaming command `dst_pass` follows `dst_valid`, and the output counter wraps from 0 to 0xFFFFFFFF.
- R7: A `stop_req` or `err_req` during an active streaming or memory-write command samples `fifo_level`. The command terminates on the edge where that many further input bytes (pads included) have been handshaked, with the byte in the request cycle included. After that number of bytes `src_ready` drops. If the number is already satisfied in the request cycle, the command terminates on that cycle's edge.
- R8: A stop or error request while no command is active, or during a memory-read command, has no effect: no result is produced and the counters and `cmd_ready` are unchanged.
- R9: A memory-read command holds `src_ready` low, leaves the input counter at its loaded value, and terminates on the edge where its output count becomes zero. This holds whatever the ignore bits are.
- R10: `mem_addr` starts at the low 11 bits of the input count field for memory-read, or of the output count field for memory-write. It advances by one after each counted output byte (memory-read) or counted input byte (memory-write), and wraps from 0x7FF to 0x000.
- R11: At termination `res_src_cnt` and `res_dst_cnt` take the counters' values after that cycle's bytes. `res_valid` pulses for one cycle. The result fields then hold until the next termination.
- R12: After reset `cmd_ready` is 1, `src_ready`, `dst_pass` and `res_valid` are 0, and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if offered |
| cmd_kind | input | 2 | 0/3 stream, 1 memory-read, 2 memory-write |
| cmd_src_cnt | input | CNT_W | Initial input byte count (memory-read: start address) |
| cmd_dst_cnt | input | CNT_W | Initial output byte count (memory-write: start address) |
| cmd_ign_src | input | 1 | Input counter free-runs and does not terminate |
| cmd_ign_dst | input | 1 | Output counter free-runs and never saturates |
| src_valid | input | 1 | Input byte offered to the processing unit |
| src_pad | input | 1 | Offered input byte is fill padding |
| src_ready | output | 1 | Input byte may be consumed this cycle |
| dst_valid | input | 1 | Output byte produced |
| dst_pad | input | 1 | Produced output byte is fill padding |
| dst_pass | output | 1 | Produced byte is forwarded (not suppressed) |
| stop_req | input | 1 | Stop request pulse |
| err_req | input | 1 | Data-error report pulse |
| fifo_level | input | LVL_W | Bytes held in the input FIFO this cycle |
| mem_addr | output | ADDR_W | Memory address for the current byte |
| res_valid | output | 1 | One-cycle pulse: result record updated |
| res_src_cnt | output | CNT_W | Final input counter value |
| res_dst_cnt | output | CNT_W | Final output counter value |
| res_src_zero | output | 1 | Ended by input count reaching zero |
| res_dst_ovr | output | 1 | Output bytes were suppressed after the count ran out |

## Verification
`src_ready`, `dst_pass` and `mem_addr` are due in the same cycle as the inputs that drive them. The bench drives at the falling edge and reads these outputs 1 ns later. The result record and its `res_valid` pulse are due one rising edge after the terminating byte or request, so they are read 1 ns after that edge. The bench's own counter model predicts the expected values on every cycle. Consequently a result that appears a cycle early or a cycle late is reported as a miscompare rather than absorbed.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;

  typedef enum logic [1:0] {
    KIND_STREAM = 2'd0,
    KIND_MEM_RD = 2'd1,
    KIND_MEM_WR = 2'd2,
    KIND_RSVD   = 2'd3
  } cmd_kind_e;

endpackage

// File: rtl/bcnt_src_ctr.sv
// Input-side byte counter: plain wrapping down-counter.
module bcnt_src_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);

  assign nxt = dec ? cnt - W'(1) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= nxt;
  end

endmodule

// File: rtl/bcnt_dst_ctr.sv
// Output-side byte counter: saturates at zero unless wrap is set,
// with a sticky overrun flag for suppressed bytes.
module bcnt_dst_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         wrap,
  input  logic         byte_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         accept,
  output logic         ovr,
  output logic         ovr_nxt
);

  assign accept  = wrap || (cnt != '0);
  assign nxt     = (byte_in && accept) ? cnt - W'(1) : cnt;
  assign ovr_nxt = ovr || (byte_in && !accept);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovr <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      ovr <= 1'b0;
    end else begin
      cnt <= nxt;
      ovr <= ovr_nxt;
    end
  end

endmodule

// File: rtl/bcnt_drain.sv
// Tracks the bytes still owed after a stop or error request.
module bcnt_drain #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             arm,
  input  logic [LVL_W-1:0] level,
  input  logic             take,
  output logic             active,
  output logic             allow,
  output logic             done
);

  logic [LVL_W-1:0] left_q;
  logic [LVL_W-1:0] eff_left;
  logic [LVL_W-1:0] rem;
  logic             eff_active;

  assign eff_active = active || arm;
  assign eff_left   = active ? left_q : level;
  assign rem        = (take && eff_left != '0) ? eff_left - LVL_W'(1) : eff_left;
  assign done       = eff_active && (rem == '0);
  assign allow      = !active || (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      active <= 1'b0;
      left_q <= '0;
    end else if (eff_active) begin
      active <= 1'b1;
      left_q <= rem;
    end
  end

endmodule

// File: rtl/bcnt_addr.sv
// 11-bit (parameterised) wrapping memory address generator.
module bcnt_addr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr + AW'(1);
  end

endmodule

// File: rtl/bcnt_term_unit.sv
module bcnt_term_unit
  import bcnt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LVL_W  = 6,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [CNT_W-1:0]  cmd_src_cnt,
  input  logic [CNT_W-1:0]  cmd_dst_cnt,
  input  logic              cmd_ign_src,
  input  logic              cmd_ign_dst,
  input  logic              src_valid,
  input  logic              src_pad,
  output logic              src_ready,
  input  logic              dst_valid,
  input  logic              dst_pad,
  output logic              dst_pass,
  input  logic              stop_req,
  input  logic              err_req,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              res_valid,
  output logic [CNT_W-1:0]  res_src_cnt,
  output logic [CNT_W-1:0]  res_dst_cnt,
  output logic              res_src_zero,
  output logic              res_dst_ovr
);

  cmd_kind_e kind_in;
  cmd_kind_e kind_q;
  logic      busy;
  logic      ign_src_q, ign_dst_q;
  logic      load, term;
  logic      is_rd, is_wr;

  assign kind_in   = cmd_kind_e'(cmd_kind);
  assign cmd_ready = !busy;
  assign load      = cmd_valid && !busy;
  assign is_rd     = busy && (kind_q == KIND_MEM_RD);
  assign is_wr     = busy && (kind_q == KIND_MEM_WR);

  // input side
  logic             drain_active, drain_allow, drain_done, arm;
  logic             take, src_dec;
  logic [CNT_W-1:0] src_cnt, src_nxt;

  assign src_ready = busy && !is_rd && drain_allow;
  assign take      = src_valid && src_ready;
  assign src_dec   = take && !src_pad;
  assign arm       = busy && !is_rd && (stop_req || err_req) && !drain_active;

  bcnt_src_ctr #(.W(CNT_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(cmd_src_cnt),
    .dec     (src_dec),
    .cnt     (src_cnt),
    .nxt     (src_nxt)
  );

  bcnt_drain #(.LVL_W(LVL_W)) u_drain (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load || term),
    .arm   (arm),
    .level (fifo_level),
    .take  (take),
    .active(drain_active),
    .allow (drain_allow),
    .done  (drain_done)
  );

  // output side
  logic             dst_wrap, dst_byte, dst_accept, dst_ovr, dst_ovr_nxt;
  logic [CNT_W-1:0] dst_cnt, dst_nxt;

  assign dst_wrap = ign_dst_q && (kind_q != KIND_MEM_RD);
  assign dst_byte = busy && dst_valid && !dst_pad;
  assign dst_pass = busy && dst_valid && dst_accept;

  bcnt_dst_ctr #(.W(CNT_W)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(cmd_dst_cnt),
    .wrap    (dst_wrap),
    .byte_in (dst_byte),
    .cnt     (dst_cnt),
    .nxt     (dst_nxt),
    .accept  (dst_accept),
    .ovr     (dst_ovr),
    .ovr_nxt (dst_ovr_nxt)
  );

  // memory address
  logic [ADDR_W-1:0] addr_base;
  logic              addr_step;

  assign addr_base = (kind_in == KIND_MEM_RD) ? cmd_src_cnt[ADDR_W-1:0]
                                              : cmd_dst_cnt[ADDR_W-1:0];
  assign addr_step = (is_rd && dst_byte && dst_accept) || (is_wr && src_dec);

  bcnt_addr #(.AW(ADDR_W)) u_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .base (addr_base),
    .step (addr_step),
    .addr (mem_addr)
  );

  // termination decision
  logic src_term, dst_term;

  assign src_term = busy && !is_rd && !ign_src_q && (src_nxt == '0);
  assign dst_term = is_rd && (dst_nxt == '0);
  assign term     = src_term || dst_term || (busy && !is_rd && drain_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kind_q    <= KIND_STREAM;
      ign_src_q <= 1'b0;
      ign_dst_q <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      kind_q    <= kind_in;
      ign_src_q <= cmd_ign_src;
      ign_dst_q <= cmd_ign_dst;
    end else if (term) begin
      busy      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_src_cnt  <= '0;
      res_dst_cnt  <= '0;
      res_src_zero <= 1'b0;
      res_dst_ovr  <= 1'b0;
    end else begin
      res_valid <= term;
      if (term) begin
        res_src_cnt  <= src_nxt;
        res_dst_cnt  <= dst_nxt;
        res_src_zero <= src_term;
        res_dst_ovr  <= dst_ovr_nxt;
      end
    end
  end

endmodule

// File: rtl/bcnt_term_unit_chk.sv
module bcnt_term_unit_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              is_rd,
  input logic              is_wr,
  input logic              ign_src_q,
  input logic              ign_dst_q,
  input logic [CNT_W-1:0]  src_cnt,
  input logic [CNT_W-1:0]  dst_cnt,
  input logic              src_valid,
  input logic              src_pad,
  input logic              src_ready,
  input logic              dst_pass,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              res_valid,
  input logic [CNT_W-1:0]  res_src_cnt,
  input logic              res_src_zero
);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!src_ready && !dst_pass));

  p_rd_no_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> !src_ready);

  p_pad_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_valid && src_ready && src_pad) |=> $stable(src_cnt));

  p_src_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ign_src_q && !is_rd && src_cnt == '0 && src_valid && src_ready && !src_pad)
      |=> (src_cnt == {CNT_W{1'b1}}));

  p_dst_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ign_dst_q && dst_cnt == '0) |-> !dst_pass);

  p_res_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_term_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cmd_ready) == 1'b0) |-> cmd_ready);

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_src_zero) |-> (res_src_cnt == '0));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && src_valid && src_ready && !src_pad)
      |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

bind bcnt_term_unit bcnt_term_unit_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .is_rd       (is_rd),
  .is_wr       (is_wr),
  .ign_src_q   (ign_src_q),
  .ign_dst_q   (ign_dst_q),
  .src_cnt     (src_cnt),
  .dst_cnt     (dst_cnt),
  .src_valid   (src_valid),
  .src_pad     (src_pad),
  .src_ready   (src_ready),
  .dst_pass    (dst_pass),
  .cmd_ready   (cmd_ready),
  .mem_addr    (mem_addr),
  .res_valid   (res_valid),
  .res_src_cnt (res_src_cnt),
  .res_src_zero(res_src_zero)
);

// File: tb/bcnt_term_unit_bench.sv
`timescale 1ns/1ps
module bcnt_term_unit_bench;

  localparam int CNT_W  = 32;
  localparam int LVL_W  = 6;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_kind = '0;
  logic [CNT_W-1:0]  cmd_src_cnt = '0;
  logic [CNT_W-1:0]  cmd_dst_cnt = '0;
  logic              cmd_ign_src = 1'b0;
  logic              cmd_ign_dst = 1'b0;
  logic              src_valid = 1'b0;
  logic              src_pad = 1'b0;
  logic              src_ready;
  logic              dst_valid = 1'b0;
  logic              dst_pad = 1'b0;
  logic              dst_pass;
  logic              stop_req = 1'b0;
  logic              err_req = 1'b0;
  logic [LVL_W-1:0]  fifo_level = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic              res_valid;
  logic [CNT_W-1:0]  res_src_cnt;
  logic [CNT_W-1:0]  res_dst_cnt;
  logic              res_src_zero;
  logic              res_dst_ovr;

  always #2.5 clk = ~clk;

  bcnt_term_unit #(.CNT_W(CNT_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_bcnt_term_unit (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_src_cnt(cmd_src_cnt), .cmd_dst_cnt(cmd_dst_cnt),
    .cmd_ign_src(cmd_ign_src), .cmd_ign_dst(cmd_ign_dst),
    .src_valid(src_valid), .src_pad(src_pad), .src_ready(src_ready),
    .dst_valid(dst_valid), .dst_pad(dst_pad), .dst_pass(dst_pass),
    .stop_req(stop_req), .err_req(err_req), .fifo_level(fifo_level),
    .mem_addr(mem_addr),
    .res_valid(res_valid), .res_src_cnt(res_src_cnt), .res_dst_cnt(res_dst_cnt),
    .res_src_zero(res_src_zero), .res_dst_ovr(res_dst_ovr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model helpers
  function automatic logic [31:0] dec_wrap(input logic [31:0] v);
    return v - 32'd1;
  endfunction

  function automatic logic [31:0] dec_sat(input logic [31:0] v);
    return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction

  task automatic start_cmd(input logic [1:0] k, input logic [31:0] s, input logic [31:0] d,
                           input bit is, input bit id);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_src_cnt = s; cmd_dst_cnt = d;
    cmd_ign_src = is; cmd_ign_dst = id;
    #1;
    chk("R1 cmd_ready before accept", cmd_ready, 1);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    chk("R1 cmd_ready low after accept", cmd_ready, 0);
  endtask

  task automatic cyc(input bit sv, input bit sp, input bit dv, input bit dp,
                     input bit stp, input bit er, input int lvl,
                     output bit took, output bit passed, output logic [10:0] addr);
    @(negedge clk);
    src_valid = sv; src_pad = sp; dst_valid = dv; dst_pad = dp;
    stop_req = stp; err_req = er; fifo_level = LVL_W'(lvl);
    #1;
    took = sv && src_ready;
    passed = dst_pass;
    addr = mem_addr;
    @(posedge clk);
    #1;
    src_valid = 0; src_pad = 0; dst_valid = 0; dst_pad = 0;
    stop_req = 0; err_req = 0; fifo_level = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit t, p;
    logic [10:0] a;
    process::self().srandom(32'h5eed_1234);

    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset cmd_ready", cmd_ready, 1);
    chk("R12 reset src_ready", src_ready, 0);
    chk("R12 reset dst_pass", dst_pass, 0);
    chk("R12 reset res_valid", res_valid, 0);
    chk("R12 reset res_src_cnt", res_src_cnt, 0);
    chk("R12 reset res_dst_cnt", res_dst_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: stop while idle is ignored
    cyc(1, 0, 1, 0, 1, 0, 2, t, p, a);
    chk("R8 idle stop no result", res_valid, 0);
    chk("R8 idle stop cmd_ready", cmd_ready, 1);
    chk("R8 idle no take", t, 0);

    // R9/R10/R8: memory read from 0x7FE, 3 bytes, stop ignored
    start_cmd(2'd1, 32'h0001_07FE, 32'd3, 1'b0, 1'b1);
    cyc(1, 0, 1, 0, 1, 0, 0, t, p, a);
    chk("R9 mem-read no src take", t, 0);
    chk("R10 rd addr 0", a, 11'h7FE);
    chk("R9 rd pass", p, 1);
    chk("R8 stop ignored in mem-read", res_valid, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, t, p, a);
    chk("R10 rd addr 1", a, 11'h7FF);
    chk("R9 rd not yet done", res_valid, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, t, p, a);
    chk("R10 rd addr wrap", a, 11'h000);
    chk("R9 rd terminates", res_valid, 1);
    chk("R9 rd dst final", res_dst_cnt, 0);
    chk("R9 rd src untouched", res_src_cnt, 32'h0001_07FE);
    cyc(0, 0, 0, 0, 0, 0, 0, t, p, a);
    chk("R11 pulse one cycle", res_valid, 0);
    chk("R11 result held", res_src_cnt, 32'h0001_07FE);

    // R10/R2/R3: memory write at 0x123, 2 bytes with a pad between
    start_cmd(2'd2, 32'd2, 32'hFFFF_F123, 1'b0, 1'b0);
    cyc(1, 0, 0, 0, 0, 0, 0, t, p, a);
    chk("R10 wr addr 0", a, 11'h123);
    cyc(1, 1, 0, 0, 0, 0, 0, t, p, a);
    chk("R10 wr addr 1", a, 11'h124);
    chk("R2 pad not counted", res_valid, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, t, p, a);
    chk("R10 pad no step", a, 11'h124);
    chk("R3 wr terminates", res_valid, 1);
    chk("R3 src zero flag", res_src_zero, 1);
    chk("R3 src final", res_src_cnt, 0);
    chk("R3 idle again", cmd_ready, 1);

    // R6/R7: output wrap, then error with empty FIFO
    start_cmd(2'd0, 32'd50, 32'd1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, 0, 0, 0, 0, t, p, a);
      chk("R6 wrap passes", p, 1);
    end
    cyc(0, 0, 0, 0, 0, 1, 0, t, p, a);
    chk("R7 error immediate", res_valid, 1);
    chk("R6 dst wrapped", res_dst_cnt, 32'hFFFF_FFFE);
    chk("R7 no zero flag", res_src_zero, 0);
    chk("R7 src final", res_src_cnt, 32'd50);

    // R5/R7: output saturation, stop with two bytes still queued
    start_cmd(2'd0, 32'd50, 32'd1, 1'b0, 1'b0);
    cyc(0, 0, 1, 0, 0, 0, 0, t, p, a);
    chk("R5 first passes", p, 1);
    cyc(0, 0, 1, 0, 0, 0, 0, t, p, a);
    chk("R5 suppressed at zero", p, 0);
    chk("R5 command continues", res_valid, 0);
    cyc(1, 0, 0, 0, 1, 0, 2, t, p, a);
    chk("R7 stop cycle take", t, 1);
    chk("R7 not yet", res_valid, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, t, p, a);
    chk("R7 drain terminates", res_valid, 1);
    chk("R7 src after drain", res_src_cnt, 32'd48);
    chk("R5 overrun flag", res_dst_ovr, 1);
    chk("R5 dst held at zero", res_dst_cnt, 0);

    // R4: input wrap with ignore bit
    start_cmd(2'd0, 32'd1, 32'd10, 1'b1, 1'b0);
    cyc(1, 0, 0, 0, 0, 0, 0, t, p, a);
    chk("R4 no term at zero", res_valid, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, t, p, a);
    chk("R4 still running", res_valid, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, t, p, a);
    chk("R7 stop ends ignore cmd", res_valid, 1);
    chk("R4 wrapped value", res_src_cnt, 32'hFFFF_FFFF);
    chk("R4 zero flag clear", res_src_zero, 0);

    // random streaming commands checked against the model
    for (int n = 0; n < 60; n++) begin
      bit is, id, ovr, drain, done;
      logic [31:0] ms, md;
      int rem, stop_at;
      is = ($urandom % 4) == 0;
      id = $urandom % 2;
      ms = 32'(1 + $urandom % 24);
      md = 32'(1 + $urandom % 24);
      start_cmd(2'd0, ms, md, is, id);
      ovr = 0; drain = 0; done = 0; rem = 0;
      stop_at = is ? int'(2 + $urandom % 20) : 100000;
      for (int c = 0; c < 300 && !done; c++) begin
        bit sv, sp, dv, dp, stp, er, term, exp_rdy, exp_pass;
        int lvl;
        sv = ($urandom % 4) != 0; sp = ($urandom % 8) == 0;
        dv = $urandom % 2;        dp = ($urandom % 8) == 0;
        stp = (c == stop_at) && ($urandom % 2);
        er  = (c == stop_at) && !stp;
        lvl = int'($urandom % 4);
        exp_rdy  = !drain || rem != 0;
        exp_pass = dv && (id || md != 0);
        cyc(sv, sp, dv, dp, stp, er, lvl, t, p, a);
        chk("R2 src handshake", t, sv && exp_rdy);
        chk("R5 R6 dst pass", p, exp_pass);
        if (t && !sp) ms = dec_wrap(ms);
        if (dv && !dp) begin
          if (id) md = dec_wrap(md);
          else if (md == 0) ovr = 1;
          else md = dec_sat(md);
        end
        term = 0;
        if ((stp || er) && !drain) begin
          drain = 1;
          rem = (lvl == 0) ? 0 : lvl - (t ? 1 : 0);
          if (rem == 0) term = 1;
        end else if (drain) begin
          if (t && rem != 0) rem--;
          if (rem == 0) term = 1;
        end
        if (!is && ms == 0) term = 1;
        chk("R3 R7 termination timing", res_valid, term);
        if (term) begin
          chk("R11 src final", res_src_cnt, ms);
          chk("R11 dst final", res_dst_cnt, md);
          chk("R3 zero flag", res_src_zero, !is && ms == 0);
          chk("R5 overrun", res_dst_ovr, ovr);
          done = 1;
        end
      end
      chk("R3 random cmd ended", done, 1);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule